// File: doc/BRIEF.md
# Bus Master Latency Timer

This block limits how long a master may keep bursting on a shared parallel bus once a transaction has begun. A configuration register holds a 5-bit latency field in its upper bits. The field is counted in steps of eight bus clocks. When the master's frame signal is first sampled high, the timer loads the field value times eight. It then counts down by one on every clock for which the frame signal stays high.

Reaching zero does not end the burst by itself. The block raises its stop request only while the timer is expired, the frame signal is still high and the arbiter has withdrawn the grant. If the grant stays asserted, the master keeps the bus for as long as it wants. The expired state holds until the frame signal drops, so a grant removed long after expiry still ends the burst on the next clock. A new frame assertion reloads the count from the register.

Top module: `burst_latency_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the register reads 0x00 and the stop request is low.
- R2: A register write stores data bits 7:3 as the latency field, and a read returns it in bits 7:3 from the cycle after the write.
- R3: Register bits 2:0 always read 0, and the values written to them are ignored.
- R4: Take a clock edge where the frame signal is sampled high after being low or idle as edge 0, with a field value F greater than 0. The count loads 8*F on edge 0 and falls by one per clock. With the grant low throughout, the stop request is first seen high after edge 8*F+1 and is low before that.
- R5: While the grant is sampled high, the stop request is low on the following cycle, whether or not the timer has expired.
- R6: Once the timer has expired, the expired state is held for as long as the frame signal stays high. A grant removed at any later point raises the stop request after the next clock edge.
- R7: A field value of 0 expires the timer on edge 0 itself, so with the grant low the stop request is seen high after edge 1.
- R8: A clock edge that samples the frame signal low clears the stop request and the timer. The next frame assertion reloads the count from the current field value.
- R9: The stop request is high only if, at the previous clock edge, the frame signal was high and the grant was low.
- R10: The counter does not wrap. Once it has reached zero, it stays at zero until a new frame assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data (bits 7:3 used) |
| reg_rd_data | output | 8 | Register read data, bits 2:0 zero |
| frame_i | input | 1 | Master frame signal, high while a transaction is in progress |
| grant_i | input | 1 | Bus grant from the arbiter, high while granted |
| stop_o | output | 1 | Registered request to the master to release the frame signal |

## Verification
The hardest case to reach is a grant taken away long after expiry. The timer must stay in its expired state through many clocks of held grant, and then react within one edge. The stimulus keeps frame and grant high well past the programmed count and then drops only the grant. A stop request one clock later shows that the expiry was held. A second hard case is the largest field value, 31, which needs 248 clocks of held frame before the request can appear.

// File: rtl/blt_pkg.sv
package blt_pkg;

    // Width of the programmable latency field
    localparam int FIELD_W    = 5;
    // Each field step is 2**UNIT_SHIFT bus clocks
    localparam int UNIT_SHIFT = 3;
    // Register and counter widths derived from the above
    localparam int REG_W      = FIELD_W + UNIT_SHIFT;
    localparam int CNT_W      = FIELD_W + UNIT_SHIFT;

    typedef logic [FIELD_W-1:0] lat_field_t;
    typedef logic [CNT_W-1:0]   lat_cnt_t;
    typedef logic [REG_W-1:0]   lat_reg_t;

    typedef enum logic [1:0] {
        TMR_IDLE    = 2'd0,
        TMR_COUNT   = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_phase_t;

    typedef struct packed {
        logic     running;
        logic     expired;
        lat_cnt_t remaining;
    } tmr_status_t;

    // Convert the coarse field into a bus-clock count
    function automatic lat_cnt_t field_to_count(input lat_field_t f);
        return lat_cnt_t'(f) << UNIT_SHIFT;
    endfunction

    // Place the field in the register image, low bits reading zero
    function automatic lat_reg_t field_to_image(input lat_field_t f);
        return {f, {UNIT_SHIFT{1'b0}}};
    endfunction

    // Extract the field from write data
    function automatic lat_field_t image_to_field(input lat_reg_t d);
        return d[REG_W-1:UNIT_SHIFT];
    endfunction

endpackage

// File: rtl/blt_cfg_reg.sv
module blt_cfg_reg
    import blt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  lat_reg_t   wr_data,
    output lat_reg_t   rd_data,
    output lat_field_t field
);

    lat_field_t field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (wr_en) begin
            field_q <= image_to_field(wr_data);
        end
    end

    assign field   = field_q;
    assign rd_data = field_to_image(field_q);

endmodule

// File: rtl/blt_countdown.sv
module blt_countdown
    import blt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_i,
    input  lat_field_t  field,
    output tmr_status_t status
);

    tmr_phase_t phase_q, phase_d;
    lat_cnt_t   cnt_q, cnt_d;
    lat_cnt_t   load_val;

    assign load_val = field_to_count(field);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!frame_i) begin
            phase_d = TMR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                TMR_IDLE: begin
                    cnt_d   = load_val;
                    phase_d = (load_val == '0) ? TMR_EXPIRED : TMR_COUNT;
                end
                TMR_COUNT: begin
                    cnt_d = cnt_q - lat_cnt_t'(1);
                    if (cnt_q == lat_cnt_t'(1)) begin
                        phase_d = TMR_EXPIRED;
                    end
                end
                TMR_EXPIRED: begin
                    cnt_d   = '0;
                    phase_d = TMR_EXPIRED;
                end
                default: begin
                    phase_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        status.running   = (phase_q != TMR_IDLE);
        status.expired   = (phase_q == TMR_EXPIRED);
        status.remaining = cnt_q;
    end

endmodule

// File: rtl/blt_stop_gen.sv
module blt_stop_gen
    import blt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tmr_status_t status,
    input  logic        frame_i,
    input  logic        grant_i,
    output logic        stop_o
);

    logic stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
        end else begin
            stop_q <= status.expired && frame_i && !grant_i;
        end
    end

    assign stop_o = stop_q;

endmodule

// File: rtl/burst_latency_timer.sv
module burst_latency_timer
    import blt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             frame_i,
    input  logic             grant_i,
    output logic             stop_o
);

    lat_field_t  field_w;
    tmr_status_t status_w;

    blt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .field   (field_w)
    );

    blt_countdown u_cnt (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .field   (field_w),
        .status  (status_w)
    );

    blt_stop_gen u_stop (
        .clk     (clk),
        .rst     (rst),
        .status  (status_w),
        .frame_i (frame_i),
        .grant_i (grant_i),
        .stop_o  (stop_o)
    );

endmodule

// File: rtl/blt_checker.sv
module blt_checker
    import blt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wr_data,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             frame_i,
    input logic             grant_i,
    input logic             stop_o,
    input tmr_status_t      status
);

    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1: one cycle after reset the outputs are idle
    always_ff @(posedge clk) begin
        if (seen_clk && !rst && $past(rst)) begin
            p_reset_idle_r1: assert (!stop_o && reg_rd_data == '0)
                else $error("reset state not idle");
        end
    end

    p_write_field_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> reg_rd_data[REG_W-1:UNIT_SHIFT] == $past(reg_wr_data[REG_W-1:UNIT_SHIFT]));

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[UNIT_SHIFT-1:0] == '0);

    p_grant_holds_bus_r5: assert property (@(posedge clk) disable iff (rst)
        grant_i |=> !stop_o);

    p_expiry_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (status.expired && frame_i) |=> status.expired);

    p_frame_low_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> (!stop_o && !status.running));

    p_stop_cause_r9: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> $past(frame_i && !grant_i));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (status.running && status.remaining == '0 && frame_i) |=> status.remaining == '0);

endmodule

bind burst_latency_timer blt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .frame_i     (frame_i),
    .grant_i     (grant_i),
    .stop_o      (stop_o),
    .status      (status_w)
);

// File: tb/burst_latency_timer_bench.sv
module burst_latency_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       frame_i = 1'b0;
    logic       grant_i = 1'b0;
    logic       stop_o;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_latency_timer u_burst_latency_timer (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .frame_i     (frame_i),
        .grant_i     (grant_i),
        .stop_o      (stop_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        frame_i = 1'b0;
        grant_i = 1'b0;
        @(negedge clk);
    endtask

    // R4 / R7: stop first appears after edge N+1, counting the loading edge as edge 0
    task automatic burst_grant_low(input logic [4:0] f, input string req);
        int n;
        int early;
        n = int'(f) * 8;
        write_reg({f, 3'b000});
        @(negedge clk);
        grant_i = 1'b0;
        frame_i = 1'b1;
        early = 0;
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (stop_o !== 1'b0) early++;
        end
        check({req, " stop low before expiry"}, 8'(early), 8'd0);
        @(negedge clk);
        check({req, " stop high after expiry"}, {7'd0, stop_o}, 8'd1);
        end_frame();
        check("R8 stop cleared after frame low", {7'd0, stop_o}, 8'd0);
    endtask

    task automatic t_reset();
        check("R1 reg reads zero in reset", reg_rd_data, 8'h00);
        check("R1 stop low in reset", {7'd0, stop_o}, 8'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reg zero after reset", reg_rd_data, 8'h00);
        check("R1 stop low after reset", {7'd0, stop_o}, 8'd0);
    endtask

    task automatic t_register();
        write_reg(8'hFF);
        check("R2/R3 write FF", reg_rd_data, 8'hF8);
        write_reg(8'h57);
        check("R2/R3 write 57", reg_rd_data, 8'h50);
        write_reg(8'h07);
        check("R3 low bits ignored", reg_rd_data, 8'h00);
    endtask

    // R5 and R6: grant held past expiry, then withdrawn
    task automatic t_grant_held();
        int seen;
        write_reg({5'd1, 3'b000});
        @(negedge clk);
        grant_i = 1'b1;
        frame_i = 1'b1;
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (stop_o !== 1'b0) seen++;
        end
        check("R5 no stop while grant held", 8'(seen), 8'd0);
        grant_i = 1'b0;
        @(negedge clk);
        check("R6 late grant removal stops", {7'd0, stop_o}, 8'd1);
        grant_i = 1'b1;
        @(negedge clk);
        check("R5 grant back clears stop", {7'd0, stop_o}, 8'd0);
        grant_i = 1'b0;
        @(negedge clk);
        check("R6 expiry still held", {7'd0, stop_o}, 8'd1);
        end_frame();
        check("R8 frame low clears", {7'd0, stop_o}, 8'd0);
    endtask

    // R8 / R10: reload on a new frame after a short gap
    task automatic t_reload();
        int early;
        write_reg({5'd2, 3'b000});
        @(negedge clk);
        frame_i = 1'b1;
        for (int k = 0; k < 30; k++) @(negedge clk);
        check("R10 stop held while expired", {7'd0, stop_o}, 8'd1);
        frame_i = 1'b0;
        @(negedge clk);
        check("R8 gap clears stop", {7'd0, stop_o}, 8'd0);
        frame_i = 1'b1;
        early = 0;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (stop_o !== 1'b0) early++;
        end
        check("R8 reload counts again", 8'(early), 8'd0);
        @(negedge clk);
        check("R8 reload expires at 16", {7'd0, stop_o}, 8'd1);
        end_frame();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_register();
        burst_grant_low(5'd2, "R4 field 2");
        burst_grant_low(5'd5, "R4 field 5");
        burst_grant_low(5'd0, "R7 field 0");
        burst_grant_low(5'd31, "R4 field 31");
        t_grant_held();
        t_reload();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule